// File: doc/BRIEF.md
# Width-Adaptive Binary Row Buffer with 3x3 Convolver

This block feeds a 3x3 binary convolution from a stream of packed one-bit feature-map rows. Each cycle it may take one 32-bit input word. The feature-map row length is 8, 16 or 32 pixels. A short row does not fill a word, so two or four consecutive rows are packed side by side. A row-select stage turns the current word and the two stored words into three aligned rows: the one above, the centre and the one below. These come out at every lane position, whatever the row length. A single convolver then needs only a per-lane edge flag to know where a row starts and ends.

For each lane, the convolver forms a nine-bit window. It XNORs the window with a nine-bit filter, counts the matching bits, and compares the count against a programmable threshold. The results give one output bit per pixel, so each accepted input word yields one 32-bit output word one cycle later. The row length is latched from a configuration input only when the buffer is cleared. Output words are flagged valid once every window they contain is built from rows received since the last clear.

Top module: `vwlb_top`

## Requirements
- R1: After reset, out_valid is 0, out_word is 0, and the buffer is empty and set to a row length of 32.
- R2: cfg_width is sampled only in a cycle with clear high. Code 0 selects 8-pixel rows, 1 selects 16, and 2 or 3 select 32. A change of cfg_width without clear has no effect.
- R3: A word holds L = 32/W rows. Row j of the word sits in bits [j*W +: W], and pixel x of that row is bit x within the row. Lower j comes earlier in the image. Rows continue from word to word.
- R4: An accepted word k (counted from 0 since the last clear) produces an output word in the next cycle. Lane j*W+x of that output is the result for pixel x of stream row k*L+j-1.
- R5: Window bit index is 3*r+c. Here r is 0 for the row above, 1 for the centre row and 2 for the row below; c is 0 for pixel x-1, 1 for pixel x and 2 for pixel x+1. The output bit is 1 when the number of positions where the window equals filter is at least thresh.
- R6: A tap at column x-1 < 0 or x+1 >= W takes the padding value 0. It never takes a pixel of a neighbouring row packed in the same word.
- R7: out_valid is 1 only when the word's first window has a real upper row: from the third word after clear at W=32, and from the second word at W=16 and W=8. An output produced before that is flagged invalid and leaves out_word unchanged.
- R8: Words may arrive on back-to-back cycles. In a cycle without in_valid, the next cycle shows out_valid 0 and out_word unchanged.
- R9: clear discards all buffered rows and has priority over in_valid in the same cycle. The next cycle shows out_valid 0 and out_word 0.
- R10: thresh 0 makes every valid output bit 1. A thresh above 9 makes every valid output bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Empty the buffer and latch cfg_width |
| cfg_width | input | 2 | Row-length code (0:8, 1:16, 2/3:32) |
| in_valid | input | 1 | in_word is accepted this cycle |
| in_word | input | 32 | Packed binary rows |
| filter | input | 9 | Binary 3x3 kernel, index 3*r+c |
| thresh | input | 4 | Match-count threshold |
| out_valid | output | 1 | out_word holds a complete row group of results |
| out_word | output | 32 | One result bit per lane |

## Verification
Several rules are checked by the assertions on every cycle:
- the row-length lock between clears;
- the legal mode code;
- the cap on the fill count;
- that out_valid only follows an accepted word;
- that a valid output never comes from the first word after a clear;
- that out_word holds through idle cycles;
- that clear flushes out_valid.

The bit values need the bench's scenarios and its own row-stream model. These include:
- how packed rows map to lanes;
- window contents across word boundaries;
- padding at row edges inside a word;
- the threshold compare;
- how many warm-up words each row length needs.

// File: rtl/vwlb_pkg.sv
package vwlb_pkg;

    localparam int TAPS  = 9;
    localparam int POP_W = 4;

    typedef logic [TAPS-1:0]  win_t;
    typedef logic [POP_W-1:0] pop_t;

    // Row roles inside the three aligned rows handed to the convolver
    typedef enum int {
        ROW_UP  = 0,
        ROW_MID = 1,
        ROW_LOW = 2
    } row_role_e;

    function automatic pop_t count_ones(input win_t v);
        pop_t s;
        s = '0;
        for (int i = 0; i < TAPS; i++) begin
            s = s + pop_t'(v[i]);
        end
        return s;
    endfunction

endpackage

// File: rtl/vwlb_bitsel.sv
// Turns the incoming word and the two stored words into three rows aligned
// lane by lane (above / centre / below), plus per-lane row-edge flags.
module vwlb_bitsel
    import vwlb_pkg::*;
#(
    parameter int MAX_W  = 32,
    parameter int MODES  = 3,
    parameter int MODE_W = 2
) (
    input  logic [MODE_W-1:0]        mode,
    input  logic [MAX_W-1:0]         cur,
    input  logic [MAX_W-1:0]         prev,
    input  logic [MAX_W-1:0]         old,
    output logic [2:0][MAX_W-1:0]    rows,
    output logic [MAX_W-1:0]         has_left,
    output logic [MAX_W-1:0]         has_right
);

    localparam int MIN_W = MAX_W >> (MODES - 1);

    // Stream order rises with bit index: oldest word in the low bits
    logic [3*MAX_W-1:0] cat;
    assign cat = {cur, prev, old};

    logic [MAX_W-1:0] up_cand  [MODES];
    logic [MAX_W-1:0] mid_cand [MODES];

    for (genvar m = 0; m < MODES; m++) begin : g_mode
        localparam int W = MIN_W << m;
        assign up_cand[m]  = cat[2*MAX_W-2*W +: MAX_W];
        assign mid_cand[m] = cat[2*MAX_W-W   +: MAX_W];
    end

    always_comb begin
        int w;
        rows[ROW_LOW] = cur;
        rows[ROW_MID] = mid_cand[MODES-1];
        rows[ROW_UP]  = up_cand[MODES-1];
        for (int m = 0; m < MODES; m++) begin
            if (mode == MODE_W'(m)) begin
                rows[ROW_MID] = mid_cand[m];
                rows[ROW_UP]  = up_cand[m];
            end
        end
        w = MIN_W << mode;
        for (int p = 0; p < MAX_W; p++) begin
            has_left[p]  = (p & (w - 1)) != 0;
            has_right[p] = (p & (w - 1)) != (w - 1);
        end
    end

endmodule

// File: rtl/vwlb_lane.sv
// One pixel: 3x3 window assembly with edge padding, XNOR match count, threshold.
module vwlb_lane
    import vwlb_pkg::*;
#(
    parameter logic PAD_BIT = 1'b0
) (
    input  logic [2:0] left_col,
    input  logic [2:0] mid_col,
    input  logic [2:0] right_col,
    input  logic       has_left,
    input  logic       has_right,
    input  win_t       filter,
    input  pop_t       thresh,
    output logic       bit_out
);

    win_t window;
    win_t match;
    pop_t hits;

    always_comb begin
        for (int r = 0; r < 3; r++) begin
            window[3*r + 0] = has_left  ? left_col[r]  : PAD_BIT;
            window[3*r + 1] = mid_col[r];
            window[3*r + 2] = has_right ? right_col[r] : PAD_BIT;
        end
        match   = ~(window ^ filter);
        hits    = count_ones(match);
        bit_out = (hits >= thresh);
    end

endmodule

// File: rtl/vwlb_conv.sv
// Width-agnostic array of lanes over the three aligned rows.
module vwlb_conv
    import vwlb_pkg::*;
#(
    parameter int   MAX_W   = 32,
    parameter logic PAD_BIT = 1'b0
) (
    input  logic [2:0][MAX_W-1:0] rows,
    input  logic [MAX_W-1:0]      has_left,
    input  logic [MAX_W-1:0]      has_right,
    input  win_t                  filter,
    input  pop_t                  thresh,
    output logic [MAX_W-1:0]      result
);

    for (genvar p = 0; p < MAX_W; p++) begin : g_lane
        logic [2:0] lc;
        logic [2:0] mc;
        logic [2:0] rc;

        assign mc = {rows[ROW_LOW][p], rows[ROW_MID][p], rows[ROW_UP][p]};

        if (p == 0) begin : g_first
            assign lc = {3{PAD_BIT}};
        end else begin : g_left
            assign lc = {rows[ROW_LOW][p-1], rows[ROW_MID][p-1], rows[ROW_UP][p-1]};
        end

        if (p == MAX_W - 1) begin : g_last
            assign rc = {3{PAD_BIT}};
        end else begin : g_right
            assign rc = {rows[ROW_LOW][p+1], rows[ROW_MID][p+1], rows[ROW_UP][p+1]};
        end

        vwlb_lane #(.PAD_BIT(PAD_BIT)) u_lane (
            .left_col  (lc),
            .mid_col   (mc),
            .right_col (rc),
            .has_left  (has_left[p]),
            .has_right (has_right[p]),
            .filter    (filter),
            .thresh    (thresh),
            .bit_out   (result[p])
        );
    end

endmodule

// File: rtl/vwlb_top.sv
module vwlb_top
    import vwlb_pkg::*;
#(
    parameter int   MAX_W   = 32,
    parameter int   MODES   = 3,
    parameter int   CFG_W   = 2,
    parameter logic PAD_BIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CFG_W-1:0] cfg_width,
    input  logic             in_valid,
    input  logic [MAX_W-1:0] in_word,
    input  logic [TAPS-1:0]  filter,
    input  logic [POP_W-1:0] thresh,
    output logic             out_valid,
    output logic [MAX_W-1:0] out_word
);

    localparam int MODE_W = (MODES > 1) ? $clog2(MODES) : 1;
    localparam int FILL_W = 2;
    localparam int HELD_W = FILL_W + MODES;
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(2);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [MAX_W-1:0]  prev;
        logic [MAX_W-1:0]  old;
        logic [FILL_W-1:0] fill;
        logic              ovalid;
        logic [MAX_W-1:0]  oword;
    } state_t;

    state_t state_d, state_q;

    logic [MODE_W-1:0]       cfg_mode;
    logic [HELD_W-1:0]       rows_held;
    logic                    window_ready;
    logic [2:0][MAX_W-1:0]   rows;
    logic [MAX_W-1:0]        has_left;
    logic [MAX_W-1:0]        has_right;
    logic [MAX_W-1:0]        conv_bits;
    logic [MODE_W-1:0]       mode_q;
    logic [FILL_W-1:0]       fill_q;

    // Out-of-range codes fall back to the widest row
    always_comb begin
        if (cfg_width >= CFG_W'(MODES)) begin
            cfg_mode = MODE_W'(MODES - 1);
        end else begin
            cfg_mode = MODE_W'(cfg_width);
        end
    end

    // Rows already stored = stored words times rows per word
    always_comb begin
        rows_held    = HELD_W'(state_q.fill) << (MODES - 1 - int'(state_q.mode));
        window_ready = rows_held >= HELD_W'(2);
    end

    vwlb_bitsel #(
        .MAX_W  (MAX_W),
        .MODES  (MODES),
        .MODE_W (MODE_W)
    ) u_bitsel (
        .mode      (state_q.mode),
        .cur       (in_word),
        .prev      (state_q.prev),
        .old       (state_q.old),
        .rows      (rows),
        .has_left  (has_left),
        .has_right (has_right)
    );

    vwlb_conv #(
        .MAX_W   (MAX_W),
        .PAD_BIT (PAD_BIT)
    ) u_conv (
        .rows      (rows),
        .has_left  (has_left),
        .has_right (has_right),
        .filter    (filter),
        .thresh    (thresh),
        .result    (conv_bits)
    );

    always_comb begin
        state_d        = state_q;
        state_d.ovalid = 1'b0;
        if (clear) begin
            state_d.mode  = cfg_mode;
            state_d.prev  = '0;
            state_d.old   = '0;
            state_d.fill  = '0;
            state_d.oword = '0;
        end else if (in_valid) begin
            state_d.old  = state_q.prev;
            state_d.prev = in_word;
            if (state_q.fill != FILL_MAX) begin
                state_d.fill = state_q.fill + FILL_W'(1);
            end
            if (window_ready) begin
                state_d.ovalid = 1'b1;
                state_d.oword  = conv_bits;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.mode <= MODE_W'(MODES - 1);
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.ovalid;
    assign out_word  = state_q.oword;
    assign mode_q    = state_q.mode;
    assign fill_q    = state_q.fill;

endmodule

// File: rtl/vwlb_check.sv
module vwlb_check #(
    parameter int MAX_W  = 32,
    parameter int MODES  = 3,
    parameter int MODE_W = 2,
    parameter int FILL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic              in_valid,
    input logic              out_valid,
    input logic [MAX_W-1:0]  out_word,
    input logic [MODE_W-1:0] mode_q,
    input logic [FILL_W-1:0] fill_q
);

    // R2: row length only moves on clear
    assert_mode_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> $stable(mode_q));

    // R2: stored mode is always a supported one
    assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(mode_q) < MODES);

    // R7: stored-word count saturates
    assert_fill_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_W'(2));

    // R7: a valid output never comes from the first word after clear
    assert_no_early_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(fill_q) != '0);

    // R8: out_valid only follows an accepted word
    assert_valid_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && !clear));

    // R8: idle cycle leaves the result word alone
    assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clear) |=> $stable(out_word));

    // R9: clear flushes the output flag and word
    assert_clear_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!out_valid && out_word == '0 && fill_q == '0));

endmodule

bind vwlb_top vwlb_check #(
    .MAX_W  (MAX_W),
    .MODES  (MODES),
    .MODE_W (MODE_W),
    .FILL_W (FILL_W)
) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_word  (out_word),
    .mode_q    (mode_q),
    .fill_q    (fill_q)
);

// File: tb/vwlb_top_test.sv
`timescale 1ns/100ps
module vwlb_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clear;
    logic [1:0]  cfg_width;
    logic        in_valid;
    logic [31:0] in_word;
    logic [8:0]  filter;
    logic [3:0]  thresh;
    logic        out_valid;
    logic [31:0] out_word;

    always #2.5 clk = ~clk;

    vwlb_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .cfg_width (cfg_width),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .filter    (filter),
        .thresh    (thresh),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    int          n_vec  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;
    int          cur_w  = 32;
    int          cur_l  = 1;
    int          nhist  = 0;
    logic [31:0] hist [64];
    logic [31:0] last_out = '0;

    function automatic logic [31:0] pat(input int k, input logic [31:0] seed);
        return (32'(k) * 32'h9E3779B1) ^ seed;
    endfunction

    // Reference: result word for word index k of the current stream
    function automatic logic [31:0] model(input int k);
        logic [31:0] r;
        for (int p = 0; p < 32; p++) begin
            int j;
            int x;
            int hits;
            j = p / cur_w;
            x = p % cur_w;
            hits = 0;
            for (int rr = 0; rr < 3; rr++) begin
                for (int cc = 0; cc < 3; cc++) begin
                    int row;
                    int col;
                    logic b;
                    row = k * cur_l + j - 2 + rr;
                    col = x + cc - 1;
                    if (row < 0 || col < 0 || col >= cur_w) b = 1'b0;
                    else b = hist[row / cur_l][(row % cur_l) * cur_w + col];
                    if (b == filter[rr*3 + cc]) hits++;
                end
            end
            r[p] = (hits >= int'(thresh));
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic exp_v, input logic [31:0] exp_w);
        n_vec++;
        if (out_valid !== exp_v || out_word !== exp_w) begin
            n_fail++;
            $display("FAIL %s: valid=%0b word=%h, expected valid=%0b word=%h",
                     tag, out_valid, out_word, exp_v, exp_w);
        end
    endtask

    task automatic push(input logic [31:0] w, input string tag);
        logic        exp_v;
        logic [31:0] exp_w;
        hist[nhist] = w;
        exp_v = (nhist * cur_l >= 2);
        exp_w = exp_v ? model(nhist) : last_out;
        in_word  = w;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (nhist < 63) nhist++;
        check(tag, exp_v, exp_w);
        last_out = exp_w;
    endtask

    task automatic idle(input int n, input string tag);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check(tag, 1'b0, last_out);
        end
    endtask

    task automatic do_clear(input logic [1:0] code, input logic with_word,
                            input logic [31:0] w, input string tag);
        cfg_width = code;
        clear     = 1'b1;
        in_valid  = with_word;
        in_word   = w;
        @(posedge clk);
        @(negedge clk);
        clear    = 1'b0;
        in_valid = 1'b0;
        cur_w    = 8 << ((code == 2'd3) ? 2 : int'(code));
        cur_l    = 32 / cur_w;
        nhist    = 0;
        last_out = '0;
        check(tag, 1'b0, 32'h0);
    endtask

    task automatic t_reset();
        check("R1 reset outputs", 1'b0, 32'h0);
        filter = 9'b110_011_101;
        thresh = 4'd5;
        for (int k = 0; k < 4; k++) push(pat(k, 32'h1357_9BDF), "R1 default width 32");
    endtask

    task automatic t_width32();
        do_clear(2'd2, 1'b0, '0, "R9 clear to 32");
        filter = 9'b101_110_011;
        thresh = 4'd5;
        for (int k = 0; k < 6; k++) push(pat(k, 32'hA5C3_0F96), "R3 R4 R5 R7 width 32");
    endtask

    task automatic t_width16();
        do_clear(2'd1, 1'b0, '0, "R9 clear to 16");
        filter = 9'b101_010_101;
        thresh = 4'd6;
        for (int k = 0; k < 5; k++) push(pat(k, 32'h0F0F_3C3C), "R3 R4 R7 width 16");
    endtask

    task automatic t_width8();
        do_clear(2'd0, 1'b0, '0, "R9 clear to 8");
        filter = 9'b010_111_010;
        thresh = 4'd3;
        for (int k = 0; k < 5; k++) push(pat(k, 32'h6B2D_91E4), "R3 R4 R7 width 8");
    endtask

    task automatic t_padding();
        do_clear(2'd0, 1'b0, '0, "R9 clear pad");
        filter = 9'h1FF;
        thresh = 4'd9;
        for (int k = 0; k < 3; k++) push(32'hFFFF_FFFF, "R6 row-edge padding width 8");
        do_clear(2'd1, 1'b0, '0, "R9 clear pad16");
        for (int k = 0; k < 3; k++) push(32'hFFFF_FFFF, "R6 row-edge padding width 16");
    endtask

    task automatic t_code3();
        do_clear(2'd3, 1'b0, '0, "R2 code 3 clear");
        filter = 9'b011_101_110;
        thresh = 4'd4;
        for (int k = 0; k < 4; k++) push(pat(k, 32'hDEAD_0001), "R2 code 3 acts as 32");
    endtask

    task automatic t_cfg_ignored();
        do_clear(2'd0, 1'b0, '0, "R2 clear to 8");
        cfg_width = 2'd2;
        filter = 9'b100_110_001;
        thresh = 4'd5;
        for (int k = 0; k < 4; k++) push(pat(k, 32'h2468_ACE0), "R2 cfg change ignored");
    endtask

    task automatic t_thresholds();
        do_clear(2'd1, 1'b0, '0, "R9 clear thr");
        filter = 9'b111_000_111;
        thresh = 4'd0;
        push(pat(0, 32'h55AA_33CC), "R10 thresh 0 warmup");
        push(pat(1, 32'h55AA_33CC), "R10 thresh 0 all ones");
        thresh = 4'd10;
        push(pat(2, 32'h55AA_33CC), "R10 thresh 10 all zeros");
    endtask

    task automatic t_gaps();
        do_clear(2'd2, 1'b0, '0, "R9 clear gaps");
        filter = 9'b001_011_111;
        thresh = 4'd5;
        push(pat(0, 32'h7777_1111), "R8 gapped stream");
        idle(2, "R8 idle hold");
        push(pat(1, 32'h7777_1111), "R8 gapped stream");
        idle(1, "R8 idle hold");
        push(pat(2, 32'h7777_1111), "R8 gapped stream");
        push(pat(3, 32'h7777_1111), "R8 back-to-back");
        idle(1, "R8 idle hold after valid");
    endtask

    task automatic t_clear_priority();
        do_clear(2'd0, 1'b1, 32'hFFFF_0000, "R9 clear with word");
        filter = 9'b000_111_000;
        thresh = 4'd4;
        push(pat(0, 32'hC0DE_F00D), "R9 word during clear dropped");
        push(pat(1, 32'hC0DE_F00D), "R9 stream after clear");
        push(pat(2, 32'hC0DE_F00D), "R9 stream after clear");
        do_clear(2'd0, 1'b0, '0, "R9 mid-stream clear");
        push(pat(3, 32'hC0DE_F00D), "R9 first word after clear");
    endtask

    initial begin
        rst_n     = 1'b0;
        clear     = 1'b0;
        cfg_width = 2'd0;
        in_valid  = 1'b0;
        in_word   = '0;
        filter    = '0;
        thresh    = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_width32();
        t_width16();
        t_width8();
        t_padding();
        t_code3();
        t_cfg_ignored();
        t_thresholds();
        t_gaps();
        t_clear_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule